// File: doc/BRIEF.md
# Dirty-Line Eviction Buffer

This block sits between a data cache and its memory port and holds exactly one evicted dirty line. When the cache controller replaces a modified line, it offers the line, its word address and the dirty flag on the load port. The buffer captures the line only when the dirty flag is set and the buffer is empty. It then keeps the line while the controller fetches the replacement line. That fetch always goes first.

Once the fill-busy indication from the cache drops, the buffer writes the line to memory as four word beats. Each beat uses a valid/ready handshake. The beats follow the same wrap-around order as the fill: the first beat is the word the miss address pointed at, and the order then wraps within the line. The starting word is captured with the line, so no outside input is needed during the drain. While the buffer holds or drains a line, `buf_full` stays high. A second dirty eviction is refused, and the controller must stall it.

Top module: `evict_buffer`

## Requirements
- R1: After reset, `buf_full`, `draining` and `mem_valid` are all 0.
- R2: A load with `ld_valid`=1 and `ld_dirty`=1 while `buf_full`=0 is captured at that clock edge, and `buf_full` is 1 from the next cycle.
- R3: A load with `ld_dirty`=0 is ignored: `buf_full` stays 0 and no memory beat is issued.
- R4: A load offered while `buf_full`=1 is refused, and the line already held is drained unchanged.
- R5: No beat is issued while `fill_busy` is 1 and a line is being held. The cycle after `fill_busy` is seen at 0 in that state, `draining` and `mem_valid` are 1.
- R6: The drain has exactly four beats. Beat k carries word offset w=(s+k) mod 4, where s is `ld_waddr[1:0]` at load time. `mem_addr` is {line address, w, 2'b00}. `mem_data` is `ld_line[32w+31:32w]`.
- R7: While `mem_valid`=1 and `mem_ready`=0, the next cycle presents the same beat: the same `mem_addr` and `mem_data`.
- R8: `mem_last` is 1 on the fourth beat only. In the cycle after that beat is accepted, `buf_full`, `draining` and `mem_valid` are 0, and a new load can be captured.
- R9: Once draining has begun, `fill_busy` has no effect. With `mem_ready` held at 1, the four beats take four consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Cache offers an evicted line |
| ld_dirty | input | 1 | Offered line is modified |
| ld_waddr | input | ADDR_W-2 | Word address of the miss; the low 2 bits give the starting word |
| ld_line | input | WORDS*WORD_W | Line data; word i is at bits [32i+31:32i] |
| fill_busy | input | 1 | Cache line fill in progress |
| buf_full | output | 1 | Buffer holds a line; further loads are refused |
| draining | output | 1 | Write-back burst in progress |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | WORD_W | Beat data |
| mem_last | output | 1 | Final beat of the burst |

## Verification
The drain is run from all four starting word offsets, so an order that failed to wrap, or that always began at word 0, would put the wrong address or data on some beat. Memory readiness is applied both as always-ready and as alternating stalls. The stalls separate a beat that is properly held from one that advances without acceptance. Holding the fill busy for several cycles shows whether the burst waits for the fill. Toggling it during a burst shows whether the burst wrongly pauses. Clean-line loads, loads offered while full and loads offered during a drain check refusal; a load right after completion checks re-arming.

// File: rtl/evict_pkg.sv
package evict_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2
  } evict_state_e;

endpackage

// File: rtl/evict_order.sv
// Wrap-around word offset for the current beat of the burst.
module evict_order #(
  parameter int WORDS = 4,
  localparam int CNT_W = $clog2(WORDS)
) (
  input  logic [CNT_W-1:0] start_ofs,
  input  logic [CNT_W-1:0] beat,
  output logic [CNT_W-1:0] word_ofs
);

  logic [CNT_W:0] sum;
  logic [CNT_W:0] wrapped;

  always_comb begin
    sum = {1'b0, start_ofs} + {1'b0, beat};
    if (sum >= (CNT_W+1)'(WORDS)) begin
      wrapped = sum - (CNT_W+1)'(WORDS);
    end else begin
      wrapped = sum;
    end
    word_ofs = wrapped[CNT_W-1:0];
  end

endmodule

// File: rtl/evict_store.sv
// Line, line address and starting word storage, with the beat word select.
module evict_store #(
  parameter int LA_W   = 28,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int CNT_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              cap_en,
  input  logic [LA_W-1:0]   in_line_addr,
  input  logic [CNT_W-1:0]  in_start,
  input  logic [LINE_W-1:0] in_data,
  input  logic [CNT_W-1:0]  sel_ofs,
  output logic [LA_W-1:0]   line_addr,
  output logic [CNT_W-1:0]  start_ofs,
  output logic [WORD_W-1:0] sel_word
);

  logic [LINE_W-1:0] data_q;
  logic [LA_W-1:0]   addr_q;
  logic [CNT_W-1:0]  start_q;
  logic [WORD_W-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (cap_en) begin
      data_q  <= in_data;
      addr_q  <= in_line_addr;
      start_q <= in_start;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_unpack
    assign words[g] = data_q[g*WORD_W +: WORD_W];
  end

  assign sel_word  = words[sel_ofs];
  assign line_addr = addr_q;
  assign start_ofs = start_q;

endmodule

// File: rtl/evict_seq.sv
// Hold / drain sequencer with the beat counter.
module evict_seq
  import evict_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int CNT_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req,
  input  logic             fill_busy,
  input  logic             mem_ready,
  output logic             cap_en,
  output logic             mem_valid,
  output logic             mem_last,
  output logic [CNT_W-1:0] beat,
  output logic             full,
  output logic             draining
);

  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(WORDS - 1);

  evict_state_e     state_q, state_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             state_en, beat_en;

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    state_en = 1'b0;
    beat_en  = 1'b0;
    cap_en   = 1'b0;
    case (state_q)
      ST_EMPTY: begin
        if (ld_req) begin
          cap_en   = 1'b1;
          state_d  = ST_HOLD;
          state_en = 1'b1;
          beat_d   = '0;
          beat_en  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!fill_busy) begin
          state_d  = ST_DRAIN;
          state_en = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (mem_ready) begin
          beat_en = 1'b1;
          if (beat_q == LAST_BEAT) begin
            beat_d   = '0;
            state_d  = ST_EMPTY;
            state_en = 1'b1;
          end else begin
            beat_d = beat_q + CNT_W'(1);
          end
        end
      end
      default: begin
        state_d  = ST_EMPTY;
        state_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign full      = (state_q != ST_EMPTY);
  assign draining  = (state_q == ST_DRAIN);
  assign mem_valid = draining;
  assign mem_last  = draining && (beat_q == LAST_BEAT);
  assign beat      = beat_q;

  // R5: a held line does not drain while the fill is still running
  assert_fill_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !draining && fill_busy) |=> !mem_valid);

  // R7: a stalled beat stays on the bus
  assert_beat_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(beat_q)));

  // R8: full only clears after the final beat is accepted
  assert_clear_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(mem_valid && mem_ready && mem_last));

  // R6: the burst stops after its last accepted beat
  assert_burst_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_last) |=> !mem_valid);

endmodule

// File: rtl/evict_buffer.sv
// Single-line dirty victim buffer between a data cache and memory.
module evict_buffer #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_valid,
  input  logic                           ld_dirty,
  input  logic [ADDR_W-$clog2(WORD_W/8)-1:0] ld_waddr,
  input  logic [WORDS*WORD_W-1:0]        ld_line,
  input  logic                           fill_busy,
  output logic                           buf_full,
  output logic                           draining,
  output logic                           mem_valid,
  input  logic                           mem_ready,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [WORD_W-1:0]              mem_data,
  output logic                           mem_last
);

  localparam int OFS_W  = $clog2(WORDS);
  localparam int BOFS_W = $clog2(WORD_W / 8);
  localparam int LA_W   = ADDR_W - OFS_W - BOFS_W;

  logic              ld_req;
  logic              cap_en;
  logic [OFS_W-1:0]  beat;
  logic [OFS_W-1:0]  start_ofs;
  logic [OFS_W-1:0]  word_ofs;
  logic [LA_W-1:0]   line_addr;

  assign ld_req = ld_valid && ld_dirty;

  evict_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_req    (ld_req),
    .fill_busy (fill_busy),
    .mem_ready (mem_ready),
    .cap_en    (cap_en),
    .mem_valid (mem_valid),
    .mem_last  (mem_last),
    .beat      (beat),
    .full      (buf_full),
    .draining  (draining)
  );

  evict_order #(.WORDS(WORDS)) u_order (
    .start_ofs (start_ofs),
    .beat      (beat),
    .word_ofs  (word_ofs)
  );

  evict_store #(.LA_W(LA_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk          (clk),
    .cap_en       (cap_en),
    .in_line_addr (ld_waddr[ADDR_W-BOFS_W-1:OFS_W]),
    .in_start     (ld_waddr[OFS_W-1:0]),
    .in_data      (ld_line),
    .sel_ofs      (word_ofs),
    .line_addr    (line_addr),
    .start_ofs    (start_ofs),
    .sel_word     (mem_data)
  );

  assign mem_addr = {line_addr, word_ofs, {BOFS_W{1'b0}}};

  // R4: a second line is never taken while one is held
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && ld_req) |-> !cap_en);

  // R7: a stalled beat keeps its address
  assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_addr));

endmodule

// File: tb/evict_buffer_test.sv
`timescale 1ns/1ps
module evict_buffer_test;

  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int WORDS  = 4;

  logic         clk;
  logic         rst_n;
  logic         ld_valid;
  logic         ld_dirty;
  logic [29:0]  ld_waddr;
  logic [127:0] ld_line;
  logic         fill_busy;
  logic         buf_full;
  logic         draining;
  logic         mem_valid;
  logic         mem_ready;
  logic [31:0]  mem_addr;
  logic [31:0]  mem_data;
  logic         mem_last;

  int errs;
  int checks;
  bit done;

  evict_buffer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_dirty(ld_dirty),
    .ld_waddr(ld_waddr), .ld_line(ld_line), .fill_busy(fill_busy),
    .buf_full(buf_full), .draining(draining), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_last(mem_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_line(input logic [31:0] seed);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = seed ^ (32'h0101_0101 * (i + 1)) ^ (i << 28);
    return l;
  endfunction

  task automatic do_load(input logic [31:0] baddr, input logic [127:0] line, input logic dirty);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_dirty = dirty;
    ld_waddr = baddr[31:2];
    ld_line  = line;
    @(negedge clk);
    ld_valid = 1'b0;
    ld_dirty = 1'b0;
  endtask

  // Entered and left at a negedge. stall: alternate mem_ready; busy_tog: toggle fill_busy;
  // spam: offer another dirty line throughout the drain.
  task automatic drain_expect(input logic [31:0] baddr, input logic [127:0] line,
                              input bit stall, input bit busy_tog, input bit spam);
    int k = 0;
    int vcyc = 0;
    bit prev_stall = 0;
    logic [31:0] prev_a = '0;
    logic [31:0] prev_d = '0;
    logic [1:0]  w;
    logic [31:0] exp_a;
    bit acc;
    if (spam) begin
      ld_valid = 1'b1; ld_dirty = 1'b1; ld_waddr = 30'h3ff_0000; ld_line = ~line;
    end
    for (int cyc = 0; cyc < 60 && k < 4; cyc++) begin
      acc = 0;
      if (mem_valid) begin
        vcyc++;
        w = baddr[3:2] + 2'(k);
        exp_a = {baddr[31:4], w, 2'b00};
        chk("R6 beat address", mem_addr, exp_a);
        chk("R6 beat data", mem_data, line[w*32 +: 32]);
        chk("R8 last flag", mem_last, (k == 3));
        if (prev_stall) begin
          chk("R7 stalled address held", mem_addr, prev_a);
          chk("R7 stalled data held", mem_data, prev_d);
        end
        mem_ready = stall ? (cyc % 2 == 1) : 1'b1;
        if (busy_tog) fill_busy = (k % 2 == 0);
        acc = mem_ready;
        prev_stall = !mem_ready;
        prev_a = mem_addr;
        prev_d = mem_data;
      end else begin
        mem_ready = 1'b0;
        prev_stall = 0;
      end
      @(negedge clk);
      if (acc) k++;
    end
    mem_ready = 1'b0;
    fill_busy = 1'b0;
    if (spam) begin
      ld_valid = 1'b0; ld_dirty = 1'b0;
    end
    chk("R6 beat count", k, 4);
    if (busy_tog && !stall) chk("R9 drain cycles unaffected by fill_busy", vcyc, 4);
    chk("R8 full cleared after last beat", buf_full, 1'b0);
    chk("R8 draining cleared", draining, 1'b0);
    chk("R8 no beat after burst", mem_valid, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ld_valid = 0; ld_dirty = 0; ld_waddr = '0; ld_line = '0;
    fill_busy = 0; mem_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1 full at reset", buf_full, 1'b0);
    chk("R1 draining at reset", draining, 1'b0);
    chk("R1 mem_valid at reset", mem_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset release", buf_full, 1'b0);
  endtask

  task automatic t_basic();
    logic [127:0] l = mk_line(32'hA5A5_0000);
    do_load(32'h0000_1230, l, 1'b1);
    chk("R2 full after load", buf_full, 1'b1);
    drain_expect(32'h0000_1230, l, 0, 0, 0);
  endtask

  task automatic t_clean();
    do_load(32'h0000_4444, mk_line(32'h1111_0000), 1'b0);
    chk("R3 clean line not captured", buf_full, 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk("R3 no beat for clean line", mem_valid, 1'b0);
    end
  endtask

  task automatic t_fill_wait();
    logic [127:0] l = mk_line(32'h5EED_0002);
    fill_busy = 1'b1;
    do_load(32'h0ABC_0008, l, 1'b1);
    repeat (5) begin
      chk("R5 no beat while fill busy", mem_valid, 1'b0);
      chk("R5 line held while fill busy", buf_full, 1'b1);
      @(negedge clk);
    end
    fill_busy = 1'b0;
    @(negedge clk);
    chk("R5 draining after fill done", draining, 1'b1);
    chk("R5 beat after fill done", mem_valid, 1'b1);
    drain_expect(32'h0ABC_0008, l, 0, 0, 0);
  endtask

  task automatic t_refuse();
    logic [127:0] la = mk_line(32'hCAFE_0001);
    fill_busy = 1'b1;
    do_load(32'h00F0_0004, la, 1'b1);
    do_load(32'h0F00_000C, mk_line(32'hDEAD_0003), 1'b1);
    chk("R4 still full after refused load", buf_full, 1'b1);
    fill_busy = 1'b0;
    drain_expect(32'h00F0_0004, la, 0, 0, 1);
  endtask

  task automatic t_backpressure();
    logic [127:0] l = mk_line(32'h7777_000C);
    do_load(32'h1234_567C, l, 1'b1);
    drain_expect(32'h1234_567C, l, 1, 0, 0);
  endtask

  task automatic t_busy_mid();
    logic [127:0] l = mk_line(32'h9999_0004);
    do_load(32'h2000_0014, l, 1'b1);
    drain_expect(32'h2000_0014, l, 0, 1, 0);
  endtask

  task automatic t_back2back();
    logic [127:0] l1 = mk_line(32'h0B0B_0001);
    logic [127:0] l2 = mk_line(32'h0C0C_0002);
    do_load(32'h3000_0008, l1, 1'b1);
    drain_expect(32'h3000_0008, l1, 0, 0, 0);
    ld_valid = 1'b1; ld_dirty = 1'b1; ld_waddr = 30'h0C00_0001; ld_line = l2;
    @(negedge clk);
    ld_valid = 1'b0; ld_dirty = 1'b0;
    chk("R8 load accepted right after burst", buf_full, 1'b1);
    drain_expect(32'h3000_0004, l2, 0, 0, 0);
  endtask

  initial begin
    errs = 0; checks = 0; done = 0;
    t_reset();
    t_basic();
    t_clean();
    t_fill_wait();
    t_refuse();
    t_backpressure();
    t_busy_mid();
    t_back2back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule